// File: doc/BRIEF.md
# Dual-Clock Shift Register with Output Latch

This block takes data in one bit at a time on a shift clock and holds it in an 8-stage shift chain. A second clock, fully independent of the first, copies the whole chain into an 8-bit output register. Only that output register drives the parallel word, so the chain can be refilled while the word last captured stays steady on the outputs.

Each of the two registers has its own active-low asynchronous clear, and each clear takes priority over its clock. The last stage of the chain comes out on a cascade pin. That pin feeds the serial input of a further instance, so wider words can be built from several instances. If both clocks come from one net, every output-clock edge captures the chain contents from just before that same edge. The parallel word therefore trails the chain by exactly one edge.

Top module: `shift_latch_reg`

## Requirements
- R1: When both clears are held low, `par_out` is all zeros and `chain_out` is 0, with no clock edge needed.
- R2: On each rising edge of `shift_clk` with `shift_clr_n` high, stage 0 takes `ser_in` and stage i takes stage i-1. `chain_out` is stage 7, so a bit reaches `chain_out` after 8 edges.
- R3: On each rising edge of `store_clk` with `store_clr_n` high, all stages are copied at once, with `par_out[i]` taking stage i.
- R4: Between `store_clk` rising edges, `par_out` holds its value whatever the shift chain does.
- R5: A low level on `shift_clr_n` zeroes every stage and `chain_out` at once, without a clock, and leaves `par_out` unchanged.
- R6: A low level on `store_clr_n` zeroes `par_out` at once and leaves the shift stages unchanged. A later `store_clk` edge shows the unchanged contents.
- R7: While a clear is low, rising edges of its clock have no effect: the stages stay zero under `shift_clr_n`, and `par_out` stays zero under `store_clr_n`.
- R8: With `chain_out` of one instance driving `ser_in` of a second, 16 bits shifted in fill both. The first bit lands in bit 7 of the second instance's word.
- R9: With `shift_clk` and `store_clk` driven together, each edge puts on `par_out` the chain contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_in | input | 1 | Serial data into stage 0 |
| shift_clk | input | 1 | Shift chain clock, rising edge |
| shift_clr_n | input | 1 | Asynchronous active-low clear of the shift chain |
| store_clk | input | 1 | Output register clock, rising edge |
| store_clr_n | input | 1 | Asynchronous active-low clear of the output register |
| par_out | output | 8 | Parallel word from the output register |
| chain_out | output | 1 | Last shift stage, for cascading |

## Verification
The hardest case to reach is a clear acting on one register while the other register keeps its value. This case also covers a clock edge that arrives while its clear is held low. The stimulus sets up a known word in both registers first. It then applies one clear with the clocks idle and reads both outputs. Next it pulses the blocked clock and checks that nothing moves. Finally it releases the clear and pulses the other clock, which brings the untouched register out to the pins. A two-instance cascade driven from one clock net then checks the one-edge lag over 16 bits.

// File: rtl/shift_latch_pkg.sv
`timescale 1ns/1ps
package shift_latch_pkg;
    localparam int unsigned SL_WIDTH_DEF = 8;
    localparam int unsigned SL_MIN_WIDTH = 2;
endpackage

// File: rtl/slr_shift_stage.sv
`timescale 1ns/1ps
module slr_shift_stage #(
    parameter int unsigned WIDTH = shift_latch_pkg::SL_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ser_in,
    output logic [WIDTH-1:0] bits_o,
    output logic             tail_o
);
    localparam int unsigned TAIL = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bits[0] = ser_in;
        for (int i = 1; i < WIDTH; i++) begin
            st_d.bits[i] = st_q.bits[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits_o = st_q.bits;
    assign tail_o = st_q.bits[TAIL];

    // Checking: armed means the previous edge happened with no clear since.
    logic armed_q;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_shift_moves_R2: assert property (@(posedge clk) disable iff (!clr_n)
        armed_q |-> (bits_o[WIDTH-1:1] == $past(bits_o[WIDTH-2:0])));

    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!clr_n)
        armed_q |-> (bits_o[0] == $past(ser_in)));

    always @(posedge clk) begin
        if (!clr_n) begin
            assert_shift_clear_holds_R7: assert (bits_o == '0 && tail_o == 1'b0);
        end
    end
endmodule

// File: rtl/slr_hold_stage.sv
`timescale 1ns/1ps
module slr_hold_stage #(
    parameter int unsigned WIDTH = shift_latch_pkg::SL_WIDTH_DEF
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] load_i,
    output logic [WIDTH-1:0] word_o
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.word = load_i;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    logic armed_q;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_hold_copies_R3: assert property (@(posedge clk) disable iff (!clr_n)
        armed_q |-> (word_o == $past(load_i)));

    always @(posedge clk) begin
        if (!clr_n) begin
            assert_hold_clear_holds_R7: assert (word_o == '0);
        end
    end
endmodule

// File: rtl/shift_latch_reg.sv
`timescale 1ns/1ps
module shift_latch_reg #(
    parameter int unsigned WIDTH = shift_latch_pkg::SL_WIDTH_DEF
) (
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             shift_clr_n,
    input  logic             store_clk,
    input  logic             store_clr_n,
    output logic [WIDTH-1:0] par_out,
    output logic             chain_out
);
    logic [WIDTH-1:0] chain_bits;

    generate
        if (WIDTH < shift_latch_pkg::SL_MIN_WIDTH) begin : g_bad_width
            initial $display("shift_latch_reg: WIDTH below minimum");
        end
    endgenerate

    slr_shift_stage #(.WIDTH(WIDTH)) u_shift (
        .clk    (shift_clk),
        .clr_n  (shift_clr_n),
        .ser_in (ser_in),
        .bits_o (chain_bits),
        .tail_o (chain_out)
    );

    slr_hold_stage #(.WIDTH(WIDTH)) u_hold (
        .clk    (store_clk),
        .clr_n  (store_clr_n),
        .load_i (chain_bits),
        .word_o (par_out)
    );
endmodule

// File: tb/shift_latch_reg_bench.sv
`timescale 1ns/1ps
module shift_latch_reg_bench;
    logic       ser_in = 1'b0;
    logic       shift_clk = 1'b0;
    logic       store_clk = 1'b0;
    logic       shift_clr_n = 1'b0;
    logic       store_clr_n = 1'b0;
    logic [7:0] par_a, par_b;
    logic       chain_a, chain_b;

    shift_latch_reg u_shift_latch_reg (
        .ser_in(ser_in), .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .par_out(par_a), .chain_out(chain_a));

    shift_latch_reg u_shift_latch_reg_hi (
        .ser_in(chain_a), .shift_clk(shift_clk), .shift_clr_n(shift_clr_n),
        .store_clk(store_clk), .store_clr_n(store_clr_n),
        .par_out(par_b), .chain_out(chain_b));

    typedef struct {
        logic [7:0] pa;
        logic [7:0] pb;
        logic       ca;
        logic       cb;
        string      tag;
    } exp_t;

    exp_t  sb_q[$];
    event  chk_ev;
    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;

    // Reference state, both instances as one 16-bit chain
    logic [15:0] m_sh = '0;
    logic [7:0]  m_pa = '0;
    logic [7:0]  m_pb = '0;

    task automatic expect_now(input string tag);
        exp_t e;
        e.pa = m_pa; e.pb = m_pb; e.ca = m_sh[7]; e.cb = m_sh[15]; e.tag = tag;
        sb_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    // Monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (par_a !== e.pa || par_b !== e.pb || chain_a !== e.ca || chain_b !== e.cb) begin
                    n_errors++;
                    $display("FAIL %s: got par=%h/%h chain=%b/%b expected par=%h/%h chain=%b/%b",
                             e.tag, par_b, par_a, chain_b, chain_a, e.pb, e.pa, e.cb, e.ca);
                end
            end
        end
    end

    task automatic shift_edge(input logic b);
        ser_in = b;
        #1;
        shift_clk = 1'b1;
        if (shift_clr_n) m_sh = {m_sh[14:0], b};
        #2.5;
        shift_clk = 1'b0;
        #1.5;
    endtask

    task automatic store_edge();
        #1;
        store_clk = 1'b1;
        if (store_clr_n) {m_pb, m_pa} = m_sh;
        #2.5;
        store_clk = 1'b0;
        #1.5;
    endtask

    task automatic both_edge(input logic b);
        ser_in = b;
        #1;
        shift_clk = 1'b1;
        store_clk = 1'b1;
        if (store_clr_n) {m_pb, m_pa} = m_sh;
        if (shift_clr_n) m_sh = {m_sh[14:0], b};
        #2.5;
        shift_clk = 1'b0;
        store_clk = 1'b0;
        #1.5;
    endtask

    task automatic set_shift_clr(input logic v);
        shift_clr_n = v;
        if (!v) m_sh = '0;
        #1;
    endtask

    task automatic set_store_clr(input logic v);
        store_clr_n = v;
        if (!v) begin m_pa = '0; m_pb = '0; end
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] pat;
        pat = 16'hA5C3;
        #3;
        expect_now("R1 clears held at start");
        set_shift_clr(1'b1);
        set_store_clr(1'b1);

        // R2 / R4: shift 16 bits through the cascade, outputs stay put
        for (int i = 15; i >= 0; i--) begin
            shift_edge(pat[i]);
            expect_now("R2 R4 serial shift step");
        end
        store_edge();
        expect_now("R3 R8 cascade capture of 16 bits");

        // R4: further shifting leaves par_out alone
        shift_edge(1'b0);
        shift_edge(1'b1);
        shift_edge(1'b1);
        expect_now("R4 output held while shifting");

        // R6: output clear only
        set_store_clr(1'b0);
        expect_now("R6 output clear zeroes word, chain kept");
        store_edge();
        expect_now("R7 store edge blocked under output clear");
        set_store_clr(1'b1);
        store_edge();
        expect_now("R6 shift contents survived output clear");

        // R5: shift clear only
        set_shift_clr(1'b0);
        expect_now("R5 shift clear zeroes chain, word kept");
        shift_edge(1'b1);
        shift_edge(1'b1);
        expect_now("R7 shift edges blocked under shift clear");
        set_shift_clr(1'b1);
        store_edge();
        expect_now("R5 stages were zeroed by shift clear");

        // R9: tied clocks, word trails the chain by one edge
        pat = 16'h3C96;
        for (int i = 15; i >= 0; i--) begin
            both_edge(pat[i]);
            expect_now("R9 tied clocks one-edge lag");
        end
        both_edge(1'b1);
        expect_now("R9 R8 tied clocks final capture");

        // R1: both clears at once
        shift_clr_n = 1'b0;
        store_clr_n = 1'b0;
        m_sh = '0; m_pa = '0; m_pb = '0;
        #1;
        expect_now("R1 both clears together");
        set_shift_clr(1'b1);
        set_store_clr(1'b1);
        expect_now("R1 released clears keep zero");

        #5;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule